// File: doc/BRIEF.md
# Fractional UART Baud Rate Generator

This block derives the receive and transmit bit-clock enables of a UART from the core clock. A binary prescaler first divides the core clock by a power of two. A fractional stage then stretches the period by a factor of (64 + N)/64. A fixed divide-by-two and a 16-step counter finish the chain. The result is a single-cycle oversampling enable at sixteen times the bit rate, and a single-cycle enable at the bit rate itself. The bit rate equals fcore / (32 × 2^DIV × (1 + N/64)). With a 16.777216 MHz core, DIV = 2 and N = 9 give 114912 bit/s.

Software programs two byte registers through a write-only port. The control register holds an enable bit and the exponent DIV. The fraction register holds N. When the enable is set, the generated ticks drive both UART clock-enable outputs and the legacy timer ticks are ignored. When the enable is clear, the legacy ticks pass straight through. Any register write restarts the whole division chain, so a new rate begins from a known phase.

A three-state controller sequences the block. ST_OFF is the idle pass-through state. ST_LOAD is a single restart cycle that holds every counter clear. ST_RUN is the active dividing state. The transitions are as follows:
- A write moves the controller from any state to ST_LOAD.
- Without a further write, ST_LOAD goes to ST_RUN when the enable is set and to ST_OFF when it is clear.
- ST_OFF and ST_RUN hold until the next write.

Top module: `frac_baud_gen`

## Requirements
- R1: After reset both registers read as zero in effect: the generator is in ST_OFF, os_tick and bit_tick are low, and the outputs follow the legacy inputs.
- R2: With the enable bit clear, rx_clk_en equals legacy_rx_tick and tx_clk_en equals legacy_tx_tick in the same cycle, and os_tick and bit_tick stay low.
- R3: With the enable bit set, the legacy inputs are ignored: rx_clk_en equals os_tick (16x enable) and tx_clk_en equals bit_tick (bit-rate enable) in every cycle.
- R4: While running, every two consecutive bit_tick intervals together last exactly 2^DIV × (64 + N) core cycles, so the mean bit period is 2^DIV × (64 + N) / 2 cycles.
- R5: Each bit_tick interval holds exactly 16 os_tick pulses, and every bit_tick coincides with an os_tick.
- R6: os_tick and bit_tick are never high in two consecutive cycles.
- R7: A register write restarts the chain. After a control write that sets the enable, the first bit_tick is high right after rising edge number 2^DIV × ceil((64 + N)/2) + 2. Edge 0 is the edge that samples the write.
- R8: Field decode works as follows. wr_addr 0 selects the control register: bit 7 is the enable, bits 2:0 are DIV, and bits 6:3 are ignored. wr_addr 1 selects the fraction register: bits 5:0 are N, and bits 7:6 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects control, 1 selects fraction |
| wr_data | input | 8 | Write data |
| legacy_rx_tick | input | 1 | Receive enable from the legacy timers |
| legacy_tx_tick | input | 1 | Transmit enable from the legacy timers |
| rx_clk_en | output | 1 | Receive clock enable to the UART |
| tx_clk_en | output | 1 | Transmit clock enable to the UART |
| os_tick | output | 1 | Generated 16x oversampling enable |
| bit_tick | output | 1 | Generated bit-rate enable |

## Verification
The assertions assume that wr_en is a clean single-cycle strobe with defined address and data, and that the fraction register does not change outside a write. This matters because the accumulator bound relies on the modulus and the accumulator clear changing at the same edge. The stimulus drives every write as a one-cycle pulse, two nanoseconds after a rising edge. The legacy inputs toggle freely, also just after a rising edge, so the comparisons made at the falling edge see settled values. Rate checks begin only after a restart marker that the driver raises after each write. As a result, no partial interval from a previous setting reaches the scoreboard.

// File: rtl/fbg_pkg.sv
package fbg_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_LOAD = 2'd1,
        ST_RUN  = 2'd2
    } fbg_state_t;

    localparam int unsigned REG_W      = 8;
    localparam int unsigned EN_BIT     = 7;
    localparam logic        ADDR_CTRL  = 1'b0;
    localparam logic        ADDR_FRAC  = 1'b1;

endpackage

// File: rtl/fbg_ctrl.sv
module fbg_ctrl
    import fbg_pkg::*;
#(
    parameter int unsigned DIV_W  = 3,
    parameter int unsigned FRAC_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    output logic              gen_en,
    output logic [DIV_W-1:0]  div_exp,
    output logic [FRAC_W-1:0] frac_n,
    output logic              run,
    output logic              clr,
    output fbg_state_t        state_o
);

    fbg_state_t state, state_nx;

    logic unused_bits;
    assign unused_bits = ^{wr_data[EN_BIT-1:DIV_W], wr_data[REG_W-1:FRAC_W]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gen_en  <= 1'b0;
            div_exp <= '0;
            frac_n  <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_CTRL) begin
                gen_en  <= wr_data[EN_BIT];
                div_exp <= wr_data[DIV_W-1:0];
            end else begin
                frac_n  <= wr_data[FRAC_W-1:0];
            end
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF:  if (wr_en) state_nx = ST_LOAD;
            ST_LOAD: begin
                if (wr_en)       state_nx = ST_LOAD;
                else if (gen_en) state_nx = ST_RUN;
                else             state_nx = ST_OFF;
            end
            ST_RUN:  if (wr_en) state_nx = ST_LOAD;
            default: state_nx = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    always_comb begin
        run = 1'b0;
        clr = wr_en;
        unique case (state)
            ST_OFF:  run = 1'b0;
            ST_LOAD: clr = 1'b1;
            ST_RUN:  run = ~wr_en;
            default: run = 1'b0;
        endcase
    end

    assign state_o = state;

    assert_load_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD && !wr_en) |=> (state != ST_LOAD));

    assert_run_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |-> gen_en);

endmodule

// File: rtl/fbg_prescaler.sv
module fbg_prescaler #(
    parameter int unsigned DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic [DIV_W-1:0] div_exp,
    output logic             pre_tick
);

    localparam int unsigned PRE_W = (1 << DIV_W) - 1;

    logic [PRE_W-1:0] cnt;
    logic [PRE_W-1:0] limit;

    assign limit    = ~({PRE_W{1'b1}} << div_exp);
    assign pre_tick = run && (cnt == limit);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= (cnt == limit) ? '0 : cnt + 1'b1;
        end
    end

endmodule

// File: rtl/fbg_frac_stage.sv
module fbg_frac_stage #(
    parameter int unsigned FRAC_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              in_tick,
    input  logic [FRAC_W-1:0] frac_n,
    output logic              out_tick
);

    localparam int unsigned ACC_W = FRAC_W + 2;
    localparam int unsigned STEP  = 1 << FRAC_W;

    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] modulus;
    logic [ACC_W-1:0] sum;

    assign modulus = ACC_W'(STEP) + ACC_W'(frac_n);
    assign sum     = acc + ACC_W'(STEP);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc      <= '0;
            out_tick <= 1'b0;
        end else if (in_tick) begin
            if (sum >= modulus) begin
                acc      <= sum - modulus;
                out_tick <= 1'b1;
            end else begin
                acc      <= sum;
                out_tick <= 1'b0;
            end
        end else begin
            out_tick <= 1'b0;
        end
    end

    assert_acc_below_mod_R4: assert property (@(posedge clk) disable iff (!rst_n)
        acc < modulus);

    assert_clear_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc == '0 && !out_tick));

endmodule

// File: rtl/fbg_os_stage.sv
module fbg_os_stage #(
    parameter int unsigned OS_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic in_tick,
    output logic os_tick,
    output logic bit_tick
);

    logic            half;
    logic [OS_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            half     <= 1'b0;
            cnt      <= '0;
            os_tick  <= 1'b0;
            bit_tick <= 1'b0;
        end else if (in_tick) begin
            half <= ~half;
            if (half) begin
                cnt      <= cnt + 1'b1;
                os_tick  <= 1'b1;
                bit_tick <= (cnt == {OS_W{1'b1}});
            end else begin
                os_tick  <= 1'b0;
                bit_tick <= 1'b0;
            end
        end else begin
            os_tick  <= 1'b0;
            bit_tick <= 1'b0;
        end
    end

    assert_bit_on_os_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> os_tick);

    assert_os_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        os_tick |=> !os_tick);

    assert_bit_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |=> !bit_tick);

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
    import fbg_pkg::*;
#(
    parameter int unsigned DIV_W  = 3,
    parameter int unsigned FRAC_W = 6,
    parameter int unsigned OS_W   = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_addr,
    input  logic [7:0] wr_data,
    input  logic       legacy_rx_tick,
    input  logic       legacy_tx_tick,
    output logic       rx_clk_en,
    output logic       tx_clk_en,
    output logic       os_tick,
    output logic       bit_tick
);

    logic              gen_en;
    logic [DIV_W-1:0]  div_exp;
    logic [FRAC_W-1:0] frac_n;
    logic              run;
    logic              clr;
    logic              pre_tick;
    logic              frac_tick;
    fbg_state_t        state;

    fbg_ctrl #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .gen_en  (gen_en),
        .div_exp (div_exp),
        .frac_n  (frac_n),
        .run     (run),
        .clr     (clr),
        .state_o (state)
    );

    fbg_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .run      (run),
        .div_exp  (div_exp),
        .pre_tick (pre_tick)
    );

    fbg_frac_stage #(.FRAC_W(FRAC_W)) u_frac (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .in_tick  (pre_tick),
        .frac_n   (frac_n),
        .out_tick (frac_tick)
    );

    fbg_os_stage #(.OS_W(OS_W)) u_os (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .in_tick  (frac_tick),
        .os_tick  (os_tick),
        .bit_tick (bit_tick)
    );

    always_comb begin
        if (gen_en) begin
            rx_clk_en = os_tick;
            tx_clk_en = bit_tick;
        end else begin
            rx_clk_en = legacy_rx_tick;
            tx_clk_en = legacy_tx_tick;
        end
    end

    assert_quiet_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF) |-> (!os_tick && !bit_tick));

    assert_quiet_in_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD) |-> !frac_tick);

endmodule

// File: tb/frac_baud_gen_bench.sv
module frac_baud_gen_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       legacy_rx_tick = 1'b0;
    logic       legacy_tx_tick = 1'b0;
    logic       rx_clk_en, tx_clk_en, os_tick, bit_tick;

    int checks = 0;
    int fails  = 0;

    int exp_q[$];
    bit mon_restart = 1'b0;
    bit en_exp = 1'b0;
    bit toggle_legacy = 1'b0;
    bit have_prev = 1'b0;
    bit half_done = 1'b0;
    bit prev_os = 1'b0;
    bit prev_bit = 1'b0;
    int cyc = 0;
    int pair = 0;
    int os_cnt = 0;

    always #5 clk = ~clk;

    frac_baud_gen u_frac_baud_gen (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_en          (wr_en),
        .wr_addr        (wr_addr),
        .wr_data        (wr_data),
        .legacy_rx_tick (legacy_rx_tick),
        .legacy_tx_tick (legacy_tx_tick),
        .rx_clk_en      (rx_clk_en),
        .tx_clk_en      (tx_clk_en),
        .os_tick        (os_tick),
        .bit_tick       (bit_tick)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // legacy tick driver, away from the active edge
    always @(posedge clk) begin
        #2;
        if (toggle_legacy) begin
            legacy_rx_tick = 1'($urandom);
            legacy_tx_tick = 1'($urandom);
        end
    end

    // monitor: measures bit intervals, pops expected pair periods and compares
    always @(negedge clk) begin
        if (rst_n) begin
            if (mon_restart) begin
                have_prev   = 1'b0;
                half_done   = 1'b0;
                cyc         = 0;
                pair        = 0;
                os_cnt      = 0;
                mon_restart = 1'b0;
            end else begin
                cyc++;
                if (os_tick) os_cnt++;
                if (bit_tick) begin
                    if (have_prev) begin
                        check(os_cnt == 16, "R5 os per bit", os_cnt, 16);
                        if (half_done) begin
                            pair += cyc;
                            if (exp_q.size() > 0) begin
                                int e;
                                e = exp_q.pop_front();
                                check((pair - e <= 1) && (e - pair <= 1), "R4 pair period", pair, e);
                            end
                            half_done = 1'b0;
                        end else begin
                            pair      = cyc;
                            half_done = 1'b1;
                        end
                    end
                    check(os_tick, "R5 bit with os", int'(os_tick), 1);
                    have_prev = 1'b1;
                    cyc       = 0;
                    os_cnt    = 0;
                end
            end
            if (os_tick)  check(!prev_os,  "R6 os single",  int'(prev_os), 0);
            if (bit_tick) check(!prev_bit, "R6 bit single", int'(prev_bit), 0);
            prev_os  = os_tick;
            prev_bit = bit_tick;
            if (en_exp) begin
                check(rx_clk_en == os_tick,  "R3 rx follows os",   int'(rx_clk_en), int'(os_tick));
                check(tx_clk_en == bit_tick, "R3 tx follows bit",  int'(tx_clk_en), int'(bit_tick));
            end
        end
    end

    task automatic reg_write(input logic a, input logic [7:0] d);
        @(posedge clk);
        #2;
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(posedge clk);
        #2;
        wr_en   = 1'b0;
    endtask

    task automatic run_rate(input int dv, input int n, input int pairs,
                            input logic [7:0] ctrl_b, input logic [7:0] frac_b,
                            input string tag);
        int lat_exp;
        int n_edges;
        reg_write(1'b1, frac_b);
        reg_write(1'b0, ctrl_b);
        en_exp      = 1'b1;
        mon_restart = 1'b1;
        for (int p = 0; p < pairs; p++) exp_q.push_back((1 << dv) * (64 + n));
        lat_exp = (1 << dv) * ((64 + n + 1) / 2) + 2;
        n_edges = 0;
        forever begin
            @(posedge clk);
            n_edges++;
            @(negedge clk);
            if (bit_tick) break;
        end
        check(n_edges == lat_exp, {"R7 restart latency ", tag}, n_edges, lat_exp);
        while (exp_q.size() > 0) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;

        // R1: reset state, idle generator, legacy pass-through
        repeat (20) begin
            @(negedge clk);
            check(!os_tick && !bit_tick, "R1 idle after reset", int'({os_tick, bit_tick}), 0);
            check(rx_clk_en == legacy_rx_tick, "R1 rx pass", int'(rx_clk_en), int'(legacy_rx_tick));
        end

        // R2: legacy inputs pass through with the enable clear
        toggle_legacy = 1'b1;
        repeat (40) begin
            @(negedge clk);
            check(rx_clk_en == legacy_rx_tick, "R2 rx pass", int'(rx_clk_en), int'(legacy_rx_tick));
            check(tx_clk_en == legacy_tx_tick, "R2 tx pass", int'(tx_clk_en), int'(legacy_tx_tick));
        end

        // R3 R4 R5 R6 R7 under several rates
        run_rate(0, 0,  6, 8'h80, 8'h00, "div0 n0");
        run_rate(2, 9,  4, 8'h82, 8'h09, "div2 n9");
        // R8: ignored bits in both registers
        run_rate(2, 9,  4, 8'hFA, 8'hC9, "R8 ignored bits");
        run_rate(3, 45, 3, 8'h83, 8'h2D, "div3 n45");
        run_rate(1, 63, 3, 8'h81, 8'h3F, "div1 n63");
        run_rate(6, 63, 2, 8'h86, 8'h3F, "div6 n63");

        // R2 again: disable while running, generator goes quiet
        reg_write(1'b0, 8'h02);
        en_exp = 1'b0;
        repeat (300) begin
            @(negedge clk);
            check(!os_tick && !bit_tick, "R2 quiet when off", int'({os_tick, bit_tick}), 0);
            check(rx_clk_en == legacy_rx_tick, "R2 rx pass", int'(rx_clk_en), int'(legacy_rx_tick));
            check(tx_clk_en == legacy_tx_tick, "R2 tx pass", int'(tx_clk_en), int'(legacy_tx_tick));
        end

        finish_run();
    end

endmodule